// File: doc/BRIEF.md
# Line-Frequency Tick Interrupt Source

This block is a periodic real-time tick generator that sits on a simple 16-bit register bus. A down-counting prescaler driven by the system clock divides it to a fixed tick rate, nominally 60 ticks per second. The divide ratio comes from two parameters: the system clock frequency and the tick frequency. The prescaler runs all the time. On each tick the block raises its interrupt request, but only if software has set the interrupt-enable bit.

Software sees a single control word. Bit 6 is the interrupt-enable flag and is the only bit that holds state. Every other bit reads as zero, and writes to those bits have no effect. A write that clears the enable bit also withdraws any request that is pending. A pending request also drops when the interrupt controller pulses the acknowledge input. A request can therefore only be present while the enable bit is set.

Top module: `lfclk_top`

## Requirements
- R1: A synchronous reset drives `irq` low, clears the enable bit so that reads return 0x0000, and restarts the prescaler. With the enable bit set, the first request appears exactly PERIOD clock edges after the reset edge, where PERIOD = SYS_HZ / TICK_HZ.
- R2: A read (`bus_sel`=1, `bus_wr`=0) returns the enable flag in bit 6 and zero in bits 15..7 and 5..0, whatever values were written to those bits.
- R3: A write to the even address (`bus_sel`=1, `bus_wr`=1, `bus_odd`=0) loads the enable flag from `bus_wdata[6]`.
- R4: A write with `bus_odd`=1 (the high byte address) leaves the enable flag and `irq` unchanged.
- R5: Ticks happen every PERIOD clock edges. When the enable bit is set at a tick edge, `irq` is high from that edge onward, and it is low in the cycle before that edge if it was cleared earlier.
- R6: The prescaler keeps running while the enable bit is clear. A tick that occurs while the bit is clear produces no request, and setting the bit later does not raise a request for that earlier tick.
- R7: An even-address write with `bus_wdata[6]`=0 drives `irq` low at the write edge, even when a tick falls on that same edge.
- R8: A one-cycle pulse on `irq_ack` clears a pending request. If a tick with the enable bit set falls on the same edge, the tick wins and `irq` stays high.
- R9: `irq` is never high while the enable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Control word selected for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_odd | input | 1 | Byte address bit 0; 1 marks the high byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when not selected) |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the ones where two events land on the same clock edge. One is a tick that coincides with an acknowledge pulse. Another is a tick that coincides with a write that clears or sets the enable bit. The tick phase is visible only through `irq`, so the bench keeps a cycle count that restarts at each reset. Ticks fall at known multiples of PERIOD in that count, and the bench times its writes and acknowledge pulses so that their edges match a tick edge exactly. A reset issued in the middle of a period then confirms that the phase restarts.

// File: rtl/lfclk_pkg.sv
package lfclk_pkg;

    localparam int CSR_W  = 16;
    localparam int IE_BIT = 6;
    localparam logic [CSR_W-1:0] IE_MASK = CSR_W'(1) << IE_BIT;

    typedef struct packed {
        logic             sel;
        logic             wr;
        logic             odd;
        logic [CSR_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic load;   // even-address write this cycle
        logic val;    // new enable value
    } ie_update_t;

    function automatic int ticks_to_cycles(input int sys_hz, input int tick_hz);
        int r;
        r = sys_hz / tick_hz;
        return (r < 1) ? 1 : r;
    endfunction

    function automatic logic [CSR_W-1:0] csr_image(input logic ie);
        return ie ? IE_MASK : '0;
    endfunction

endpackage

// File: rtl/lfclk_prescaler.sv
module lfclk_prescaler #(
    parameter int PERIOD = 16,
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= RELOAD;
        else if (cnt == '0)
            cnt <= RELOAD;
        else
            cnt <= cnt - 1'b1;
    end

    assign tick = (cnt == '0);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= RELOAD); // R5
    AST_TICK_RELOADS: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == RELOAD)); // R5

endmodule

// File: rtl/lfclk_ctrl_reg.sv
module lfclk_ctrl_reg
    import lfclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic             ie,
    output ie_update_t       upd,
    output logic [CSR_W-1:0] rdata
);
    always_comb begin
        upd.load = req.sel && req.wr && !req.odd;
        upd.val  = |(req.wdata & IE_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ie <= 1'b0;
        else if (upd.load)
            ie <= upd.val;
    end

    assign rdata = req.sel ? csr_image(ie) : '0;

    AST_ODD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (req.sel && req.wr && req.odd) |=> $stable(ie)); // R4
    AST_ONLY_IE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~IE_MASK) == '0); // R2

endmodule

// File: rtl/lfclk_irq_latch.sv
module lfclk_irq_latch
    import lfclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ie,
    input  ie_update_t upd,
    input  logic       ack,
    output logic       irq
);
    logic disable_wr;
    assign disable_wr = upd.load && !upd.val;

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (disable_wr)
            irq <= 1'b0;
        else if (tick && ie)
            irq <= 1'b1;
        else if (ack)
            irq <= 1'b0;
    end

    AST_DISABLE_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        disable_wr |=> !irq); // R7
    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (ack && !(tick && ie)) |=> !irq); // R8
    AST_TICK_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
        (tick && ie && !disable_wr) |=> irq); // R5

endmodule

// File: rtl/lfclk_top.sv
module lfclk_top
    import lfclk_pkg::*;
#(
    parameter int SYS_HZ  = 50_000_000,
    parameter int TICK_HZ = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_odd,
    input  logic [CSR_W-1:0] bus_wdata,
    output logic [CSR_W-1:0] bus_rdata,
    input  logic             irq_ack,
    output logic             irq
);
    localparam int PERIOD = ticks_to_cycles(SYS_HZ, TICK_HZ);

    bus_req_t   req;
    ie_update_t upd;
    logic       ie;
    logic       tick;

    always_comb begin
        req.sel   = bus_sel;
        req.wr    = bus_wr;
        req.odd   = bus_odd;
        req.wdata = bus_wdata;
    end

    lfclk_prescaler #(.PERIOD(PERIOD)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    lfclk_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .ie    (ie),
        .upd   (upd),
        .rdata (bus_rdata)
    );

    lfclk_irq_latch u_irq (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .ie   (ie),
        .upd  (upd),
        .ack  (irq_ack),
        .irq  (irq)
    );

    AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie); // R9

endmodule

// File: tb/sim_lfclk_top.sv
module sim_lfclk_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_odd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_ack = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    int          q_cyc[$];
    logic        q_irq[$];
    logic [15:0] q_rd[$];
    bit          q_chk_rd[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lfclk_top #(.SYS_HZ(N*60), .TICK_HZ(60)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_odd(bus_odd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // monitor: pops expectations for the current cycle and compares
    always @(negedge clk) begin
        #1;
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            int          ec;
            logic        ei;
            logic [15:0] er;
            bit          cr;
            string       t;
            ec = q_cyc.pop_front();
            ei = q_irq.pop_front();
            er = q_rd.pop_front();
            cr = q_chk_rd.pop_front();
            t  = q_tag.pop_front();
            tests++;
            if (ec != cyc) begin
                fails++;
                $display("FAIL %s: expectation for cycle %0d seen at cycle %0d", t, ec, cyc);
            end else if (irq !== ei) begin
                fails++;
                $display("FAIL %s: cycle %0d irq actual %b expected %b", t, cyc, irq, ei);
            end else if (cr && bus_rdata !== er) begin
                fails++;
                $display("FAIL %s: cycle %0d rdata actual %h expected %h", t, cyc, bus_rdata, er);
            end
        end
    end

    task automatic expect_now(input logic ei, input bit cr, input logic [15:0] er, input string t);
        q_cyc.push_back(cyc);
        q_irq.push_back(ei);
        q_rd.push_back(er);
        q_chk_rd.push_back(cr);
        q_tag.push_back(t);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    task automatic bus_write(input logic odd, input logic [15:0] d);
        bus_wr = 1'b1; bus_odd = odd; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_odd = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_now(1'b0, 1, 16'h0000, "R1 reset state");
        wait_cyc(17);
        expect_now(1'b0, 1, 16'h0000, "R6 tick with enable clear");
        wait_cyc(20);
        bus_write(1'b0, 16'hFFFF);
        expect_now(1'b0, 1, 16'h0040, "R2 R3 only enable bit reads back");
        wait_cyc(31);
        expect_now(1'b0, 0, '0, "R6 no late request for earlier tick");
        wait_cyc(32);
        expect_now(1'b1, 0, '0, "R5 request on tick");
        wait_cyc(34);
        pulse_ack();
        expect_now(1'b0, 0, '0, "R8 acknowledge clears");
        wait_cyc(47);
        expect_now(1'b0, 0, '0, "R5 period before next tick");
        wait_cyc(48);
        expect_now(1'b1, 0, '0, "R5 next tick");
        wait_cyc(50);
        bus_write(1'b1, 16'h0000);
        expect_now(1'b1, 1, 16'h0040, "R4 odd byte write ignored");
        wait_cyc(52);
        bus_write(1'b0, 16'hFFBF);
        expect_now(1'b0, 1, 16'h0000, "R7 R2 disable clears request");
        wait_cyc(65);
        expect_now(1'b0, 0, '0, "R9 no request while disabled");
        wait_cyc(70);
        bus_write(1'b0, 16'h0040);
        wait_cyc(79);
        expect_now(1'b0, 0, '0, "R5 before collision tick");
        pulse_ack();
        expect_now(1'b1, 0, '0, "R8 tick wins over acknowledge");
        wait_cyc(95);
        bus_write(1'b0, 16'h0000);
        expect_now(1'b0, 1, 16'h0000, "R7 disable on tick edge");
        wait_cyc(111);
        bus_write(1'b0, 16'h0040);
        expect_now(1'b0, 1, 16'h0040, "R6 enable on tick edge not retroactive");
        wait_cyc(127);
        expect_now(1'b0, 0, '0, "R9 R5 low before tick");
        wait_cyc(128);
        expect_now(1'b1, 0, '0, "R5 tick after re-enable");
        wait_cyc(130);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_now(1'b0, 1, 16'h0000, "R1 mid-period reset clears");
        wait_cyc(2);
        bus_write(1'b0, 16'h0040);
        wait_cyc(15);
        expect_now(1'b0, 0, '0, "R1 timer restarted");
        wait_cyc(16);
        expect_now(1'b1, 0, '0, "R1 first tick after reset");
        @(negedge clk);
        @(negedge clk);
        if (q_cyc.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q_cyc.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule